// File: doc/BRIEF.md
# Clock Synthesizer Divider Search Unit

This unit picks the three divider settings of a fractional-free clock synthesizer: an input (pre) divider, an integer loop multiplier and a power-of-two output divider. It is given the reference frequency and the wanted output frequency, both in kHz, plus the lowest and highest permitted lane bit rates. From the two lane rates it derives the permitted oscillator window. It then walks the input divider upwards and, for each one, walks the output divider through its four powers of two. For every pair it computes the nearest integer multiplier and throws the pair away when that multiplier leaves the window-derived bounds. Of the surviving candidates it keeps the one whose achieved frequency is closest to the target.

All divisions go through one shared shift-subtract divider, so a search lasts from a few hundred to a few thousand cycles. The caller pulses `start` while the unit is idle and waits for the one-cycle `done` pulse. The results, an invalid-argument flag and a no-solution flag then stay put until the next accepted `start`.

States: `S_IDLE` (waits for start; goes to `S_DONE` on bad arguments, otherwise to `S_LO`), `S_LO` (issues the lower-bound division and goes to `S_WAIT`), `S_WAIT` (waits for the divider, then goes to the stored return state), `S_LO_CHK` (goes to `S_DONE` when the raw lower bound has reached the multiplier ceiling, otherwise issues the upper-bound division), `S_HI_CHK` (stores the clamped upper bound and issues the first multiplier division), `S_N_CHK` (goes to `S_NEXT` when the multiplier is out of bounds, otherwise issues the achieved-frequency division), `S_CMP` (keeps a better candidate; goes to `S_DONE` on zero error, otherwise to `S_NEXT`), `S_NEXT` (goes to the next output divider, or to the next input divider through `S_LO`, or to `S_DONE` after the last one), and `S_DONE` (goes back to `S_IDLE` and raises `done` in the following cycle).

Top module: `pll_div_search`

## Requirements
- R1: If `fin_khz` or `fout_khz`, read as two's-complement signed, is zero or negative, the unit does no search: `done` pulses with `err_inval`=1, `no_solution`=0 and `idf`, `ndiv`, `odf` and `odf_log2` all zero.
- R2: A reported solution has `idf` in 1..7, `ndiv` in 10..125 and `odf` in {1,2,4,8}, and `odf` equals 2 raised to `odf_log2` (log2 code 0..3).
- R3: The oscillator window is vmin = 16*`lane_min_kbps` to vmax = 2*`lane_max_kbps`. For input divider i the multiplier bounds are floor(vmin*i/(2*fin))+1 and floor(vmax*i/(2*fin)), clamped to at least 10 and at most 125.
- R4: For each pair (i, o), the candidate multiplier is round-to-nearest of i*o*fout/fin, i.e. floor((i*o*fout + floor(fin/2))/fin), and the pair is skipped when this lies outside the bounds of R3.
- R5: The achieved frequency is floor((fin*n + floor(i*o/2))/(i*o)). A candidate replaces the stored one only when its absolute error to fout is strictly smaller. The starting error is 1,000,000. Candidates are visited with i ascending from 1 and o doubling from 1 within each i.
- R6: A candidate with zero error ends the search at once and is reported.
- R7: When the unclamped lower bound for some i is 125 or more, no further input dividers are tried.
- R8: If no candidate is accepted, `done` pulses with `no_solution`=1, `err_inval`=0 and all divider outputs zero.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` lasts exactly one cycle, in the cycle where `busy` has just fallen. Results hold unchanged while the unit is idle.
- R10: A `start` pulse while `busy` is high is ignored, and the running search reports the result for its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| fin_khz | input | 32 | Reference frequency in kHz, signed |
| fout_khz | input | 32 | Wanted output frequency in kHz, signed |
| lane_min_kbps | input | 32 | Lowest permitted lane rate |
| lane_max_kbps | input | 32 | Highest permitted lane rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| idf | output | 3 | Chosen input divider |
| ndiv | output | 7 | Chosen loop multiplier |
| odf | output | 4 | Chosen output divider |
| odf_log2 | output | 2 | Output divider as log2 code |
| err_inval | output | 1 | Bad frequency argument |
| no_solution | output | 1 | No candidate fits the window |

## Verification
The search length depends on how many divisions run, so no result has a fixed delay after `start`. The invalid-argument result comes two cycles after the accepted `start` (through `S_DONE`), and every other result comes one cycle after the search reaches `S_DONE`. The bench therefore polls `done` at falling edges and samples every result output in the same falling-edge slot where `done` is first seen high. It then checks one cycle later that `done` has dropped, and some twenty idle cycles later that the outputs have held.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LO,
        S_WAIT,
        S_LO_CHK,
        S_HI_CHK,
        S_N_CHK,
        S_CMP,
        S_NEXT,
        S_DONE
    } srch_state_t;

endpackage

// File: rtl/pll_seq_div.sv
// Shift-subtract unsigned divider, one quotient bit per cycle.
module pll_seq_div #(
    parameter int W = 40,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);
    logic          run;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rem;
    logic [W-1:0]  den_r;
    logic [W:0]    trial;

    assign trial = {rem, quot[W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run   <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            den_r <= '0;
            quot  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !run) begin
                run   <= 1'b1;
                cnt   <= CW'(W);
                rem   <= '0;
                den_r <= den;
                quot  <= num;
            end else if (run) begin
                if (trial >= {1'b0, den_r}) begin
                    rem  <= W'(trial - {1'b0, den_r});
                    quot <= {quot[W-2:0], 1'b1};
                end else begin
                    rem  <= trial[W-1:0];
                    quot <= {quot[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pll_abs_diff.sv
module pll_abs_diff #(
    parameter int W = 40
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        if (a >= b) y = a - b;
        else        y = b - a;
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int FW       = 32,
    parameter int IDIV_MAX = 7,
    parameter int NMUL_MIN = 10,
    parameter int NMUL_MAX = 125,
    parameter int OLOG_MAX = 3,
    parameter int ERR_INIT = 1000000,
    localparam int DW  = FW + 8,
    localparam int IW  = $clog2(IDIV_MAX + 1),
    localparam int NW  = $clog2(NMUL_MAX + 1),
    localparam int OLW = $clog2(OLOG_MAX + 1),
    localparam int OW  = OLOG_MAX + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [FW-1:0] fin_khz,
    input  logic signed [FW-1:0] fout_khz,
    input  logic [FW-1:0]        lane_min_kbps,
    input  logic [FW-1:0]        lane_max_kbps,
    output logic                 busy,
    output logic                 done,
    output logic [IW-1:0]        idf,
    output logic [NW-1:0]        ndiv,
    output logic [OW-1:0]        odf,
    output logic [OLW-1:0]       odf_log2,
    output logic                 err_inval,
    output logic                 no_solution
);
    srch_state_t state, state_d, ret_st;

    logic [DW-1:0]  fin_r, fout_r, vmin_r, vmax_r, best_r;
    logic [IW-1:0]  i_r;
    logic [OLW-1:0] olog_r;
    logic [NW-1:0]  nmin_r, nmax_r, n_r;
    logic           found_r;

    logic           div_go, div_done;
    logic [DW-1:0]  div_num, div_den, q, delta, io;
    logic           bad_args, lo_stop, n_bad, last_o, last_i;

    pll_seq_div #(.W(DW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quot (q)
    );

    pll_abs_diff #(.W(DW)) u_err (
        .a(q),
        .b(fout_r),
        .y(delta)
    );

    assign bad_args = (fin_khz <= 0) || (fout_khz <= 0);
    assign io       = DW'(i_r) << olog_r;
    assign lo_stop  = (q + 1'b1) >= DW'(NMUL_MAX);
    assign n_bad    = (q < DW'(nmin_r)) || (q > DW'(nmax_r));
    assign last_o   = (olog_r == OLW'(OLOG_MAX));
    assign last_i   = (i_r == IW'(IDIV_MAX));
    assign busy     = (state != S_IDLE);

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:   if (start) state_d = bad_args ? S_DONE : S_LO;
            S_LO:     state_d = S_WAIT;
            S_WAIT:   if (div_done) state_d = ret_st;
            S_LO_CHK: state_d = lo_stop ? S_DONE : S_WAIT;
            S_HI_CHK: state_d = S_WAIT;
            S_N_CHK:  state_d = n_bad ? S_NEXT : S_WAIT;
            S_CMP:    state_d = (delta == '0) ? S_DONE : S_NEXT;
            S_NEXT:   state_d = !last_o ? S_WAIT : (!last_i ? S_LO : S_DONE);
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_st <= S_IDLE;
            fin_r <= '0; fout_r <= '0; vmin_r <= '0; vmax_r <= '0; best_r <= '0;
            i_r <= '0; olog_r <= '0; nmin_r <= '0; nmax_r <= '0; n_r <= '0;
            found_r <= 1'b0;
            div_go <= 1'b0; div_num <= '0; div_den <= '0;
            done <= 1'b0; idf <= '0; ndiv <= '0; odf <= '0; odf_log2 <= '0;
            err_inval <= 1'b0; no_solution <= 1'b0;
        end else begin
            div_go <= 1'b0;
            done   <= (state == S_DONE);
            unique case (state)
                S_IDLE: if (start) begin
                    fin_r       <= DW'($unsigned(fin_khz));
                    fout_r      <= DW'($unsigned(fout_khz));
                    vmin_r      <= DW'(lane_min_kbps) << (OLOG_MAX + 1);
                    vmax_r      <= DW'(lane_max_kbps) << 1;
                    best_r      <= DW'(ERR_INIT);
                    i_r         <= IW'(1);
                    olog_r      <= '0;
                    found_r     <= 1'b0;
                    idf         <= '0;
                    ndiv        <= '0;
                    odf         <= '0;
                    odf_log2    <= '0;
                    err_inval   <= bad_args;
                    no_solution <= 1'b0;
                end
                S_LO: begin
                    div_go  <= 1'b1;
                    div_num <= vmin_r * DW'(i_r);
                    div_den <= fin_r << 1;
                    ret_st  <= S_LO_CHK;
                end
                S_WAIT: ;
                S_LO_CHK: if (!lo_stop) begin
                    nmin_r  <= ((q + 1'b1) < DW'(NMUL_MIN)) ? NW'(NMUL_MIN) : NW'(q + 1'b1);
                    div_go  <= 1'b1;
                    div_num <= vmax_r * DW'(i_r);
                    div_den <= fin_r << 1;
                    ret_st  <= S_HI_CHK;
                end
                S_HI_CHK: begin
                    nmax_r  <= (q > DW'(NMUL_MAX)) ? NW'(NMUL_MAX) : NW'(q);
                    div_go  <= 1'b1;
                    div_num <= ((DW'(i_r) * fout_r) << olog_r) + (fin_r >> 1);
                    div_den <= fin_r;
                    ret_st  <= S_N_CHK;
                end
                S_N_CHK: if (!n_bad) begin
                    n_r     <= NW'(q);
                    div_go  <= 1'b1;
                    div_num <= (fin_r * q) + (io >> 1);
                    div_den <= io;
                    ret_st  <= S_CMP;
                end
                S_CMP: if (delta < best_r) begin
                    best_r   <= delta;
                    idf      <= i_r;
                    ndiv     <= n_r;
                    odf      <= OW'(1) << olog_r;
                    odf_log2 <= olog_r;
                    found_r  <= 1'b1;
                end
                S_NEXT: begin
                    if (!last_o) begin
                        olog_r  <= olog_r + 1'b1;
                        div_go  <= 1'b1;
                        div_num <= ((DW'(i_r) * fout_r) << (olog_r + 1'b1)) + (fin_r >> 1);
                        div_den <= fin_r;
                        ret_st  <= S_N_CHK;
                    end else if (!last_i) begin
                        i_r    <= i_r + 1'b1;
                        olog_r <= '0;
                    end
                end
                S_DONE: no_solution <= !err_inval && !found_r;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
    parameter int IW  = 3,
    parameter int NW  = 7,
    parameter int OW  = 4,
    parameter int OLW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [IW-1:0]  idf,
    input logic [NW-1:0]  ndiv,
    input logic [OW-1:0]  odf,
    input logic [OLW-1:0] odf_log2,
    input logic           err_inval,
    input logic           no_solution
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(idf) && $stable(ndiv) && $stable(odf)
                               && $stable(odf_log2) && $stable(err_inval)
                               && $stable(no_solution)));

    assert_ranges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_inval && !no_solution) |->
            (idf >= 1 && idf <= 7 && ndiv >= 10 && ndiv <= 125 && $onehot(odf)
             && odf == (OW'(1) << odf_log2)));

    assert_inval_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_inval) |-> (idf == '0 && ndiv == '0 && odf == '0 && !no_solution));

    assert_nosol_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_solution) |-> (idf == '0 && ndiv == '0 && odf == '0 && !err_inval));
endmodule

bind pll_div_search pll_div_search_chk #(
    .IW(IW), .NW(NW), .OW(OW), .OLW(OLW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .idf(idf), .ndiv(ndiv), .odf(odf), .odf_log2(odf_log2),
    .err_inval(err_inval), .no_solution(no_solution)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NV         = 10;

    // stimulus: fin, fout, lane min, lane max; expected flags: invalid, no solution
    localparam longint V_FIN  [NV] = '{25000, 27000, 24000, 8000, 50000, 30000, 1000, 48000, 25000, -100};
    localparam longint V_FOUT [NV] = '{500000, 401234, 333333, 100000, 62500, 777777, 500000, 40000, 0, 5000};
    localparam longint V_LMIN [NV] = '{31250, 31250, 62500, 31250, 31250, 62500, 31250, 31250, 31250, 31250};
    localparam longint V_LMAX [NV] = '{500000, 500000, 1000000, 500000, 500000, 1000000, 500000, 31250, 500000, 500000};
    localparam bit     V_INV  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
    localparam bit     V_NOS  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic signed [31:0] fin_khz = '0, fout_khz = '0;
    logic [31:0] lane_min_kbps = '0, lane_max_kbps = '0;
    logic        busy, done, err_inval, no_solution;
    logic [2:0]  idf;
    logic [6:0]  ndiv;
    logic [3:0]  odf;
    logic [1:0]  odf_log2;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int  e_i, e_n, e_o, e_l;
    bit  e_inv, e_nos;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_div_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fin_khz(fin_khz), .fout_khz(fout_khz),
        .lane_min_kbps(lane_min_kbps), .lane_max_kbps(lane_max_kbps),
        .busy(busy), .done(done), .idf(idf), .ndiv(ndiv), .odf(odf),
        .odf_log2(odf_log2), .err_inval(err_inval), .no_solution(no_solution)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference search written from the requirements
    task automatic model(input longint fin, input longint fout, input longint lmin, input longint lmax);
        longint vmin, vmax, best, nlo, nhi, n, ach, d;
        bit stop;
        vmin = lmin * 16; vmax = lmax * 2; best = 1000000; stop = 0;
        e_i = 0; e_n = 0; e_o = 0; e_l = 0; e_nos = 0;
        e_inv = (fin <= 0) || (fout <= 0);
        if (!e_inv) begin
            for (int i = 1; i <= 7 && !stop; i++) begin
                nlo = (vmin * i) / (2 * fin) + 1;
                if (nlo >= 125) stop = 1;
                else begin
                    if (nlo < 10) nlo = 10;
                    nhi = (vmax * i) / (2 * fin);
                    if (nhi > 125) nhi = 125;
                    for (int o = 1; o <= 8 && !stop; o = o * 2) begin
                        n = (i * o * fout + fin / 2) / fin;
                        if (n >= nlo && n <= nhi) begin
                            ach = (fin * n + (i * o) / 2) / (i * o);
                            d = ach - fout;
                            if (d < 0) d = -d;
                            if (d < best) begin
                                best = d; e_i = i; e_n = int'(n); e_o = o;
                            end
                            if (d == 0) stop = 1;
                        end
                    end
                end
            end
            e_nos = (e_i == 0);
        end
        e_l = (e_o == 8) ? 3 : (e_o == 4) ? 2 : (e_o == 2) ? 1 : 0;
    endtask

    task automatic launch(input longint fin, input longint fout, input longint lmin, input longint lmax);
        @(negedge clk);
        fin_khz = 32'(fin); fout_khz = 32'(fout);
        lane_min_kbps = 32'(lmin); lane_max_kbps = 32'(lmax);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        int cnt;
        cnt = 0;
        while (!done && cnt < 20000) begin
            @(negedge clk);
            cnt++;
        end
        seen = done;
    endtask

    task automatic compare_all(input string tag);
        check(err_inval == e_inv, {tag, " R1 err_inval"}, err_inval, e_inv);
        check(no_solution == e_nos, {tag, " R8 no_solution"}, no_solution, e_nos);
        check(idf == 3'(e_i), {tag, " R3 R5 R6 R7 idf"}, idf, e_i);
        check(ndiv == 7'(e_n), {tag, " R4 R5 ndiv"}, ndiv, e_n);
        check(odf == 4'(e_o), {tag, " R2 R5 odf"}, odf, e_o);
        check(odf_log2 == 2'(e_l), {tag, " R2 odf_log2"}, odf_log2, e_l);
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // reset state
        check(!busy && !done, "R9 reset busy/done", {busy, done}, 0);
        check(idf == 0 && ndiv == 0 && odf == 0 && !err_inval && !no_solution,
              "R9 reset outputs", {idf, ndiv, odf}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk
        for (int k = 0; k < NV; k++) begin
            model(V_FIN[k], V_FOUT[k], V_LMIN[k], V_LMAX[k]);
            check(e_inv == V_INV[k] && e_nos == V_NOS[k], "table flags", {e_inv, e_nos}, {V_INV[k], V_NOS[k]});
            launch(V_FIN[k], V_FOUT[k], V_LMIN[k], V_LMAX[k]);
            wait_done(seen);
            check(seen, "R9 done seen", seen, 1);
            check(!busy, "R9 busy low at done", busy, 0);
            compare_all($sformatf("vec%0d", k));
            @(negedge clk);
            check(!done, "R9 done one cycle", done, 0);
        end

        // R6: exact match on first candidate, hand values
        launch(25000, 500000, 31250, 500000);
        wait_done(seen);
        check(idf == 1 && ndiv == 20 && odf == 1 && odf_log2 == 0,
              "R6 exact first candidate", {idf, ndiv, odf}, {3'd1, 7'd20, 4'd1});

        // R7: reference so low that the first lower bound is already past the ceiling
        launch(1000, 500000, 31250, 500000);
        wait_done(seen);
        check(no_solution && idf == 0 && ndiv == 0, "R7 stop gives no solution", no_solution, 1);

        // R10: start while busy is ignored
        model(27000, 401234, 31250, 500000);
        launch(27000, 401234, 31250, 500000);
        repeat (5) @(negedge clk);
        check(busy, "R10 busy mid search", busy, 1);
        fin_khz = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        compare_all("R10 ignored start");

        // R9: outputs hold while idle
        repeat (20) @(negedge clk);
        check(!done && !busy, "R9 idle after done", {done, busy}, 0);
        check(idf == 3'(e_i) && ndiv == 7'(e_n) && odf == 4'(e_o), "R9 hold", ndiv, e_n);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule